// File: doc/BRIEF.md
# Polyphase Horizontal Line Resampler

This block resizes one line of 8-bit pixel components along the horizontal axis. It uses an 8-tap FIR filter with 32 selectable phases. Input samples arrive on a valid/ready stream with start-of-line and end-of-line markers. The block stores the line, then walks a 16.16 fixed-point position across it. For every output pixel it picks a filter phase and a centre sample, and it forms a weighted sum of eight neighbouring samples.

Software computes the step as the input width shifted left by sixteen, divided by the output width. It also chooses an initial phase, which seeds the position at the start of every line. The filter weights are written into a staging bank through a simple word write port. They reach the filter only when a commit strobe copies the staging bank into the working bank. One instance serves one component channel.

Top module: `hscale_top`

## Requirements
- R1: Coefficient word address = phase*2 + half. Half 0 holds taps 0..3 and half 1 holds taps 4..7. Within a word, tap (half*4+b) sits in bits [8b+7:8b] as a two's-complement byte.
- R2: Writes go only to the staging bank and do not change any output. A one-cycle `coef_commit` pulse copies the whole staging bank into the working bank. The copied set is used from the next filtered output onward.
- R3: The 32-bit position register loads `cfg_init_phase` when a line closes and advances by `cfg_step` after each output. Bits [31:16] give the centre sample index and bits [15:11] give the phase.
- R4: Tap t (0..7) reads sample index centre+t-3. An index below 0 uses sample 0, and an index past the last stored sample uses the last stored sample.
- R5: Each output is sum(tap*sample), plus 32, arithmetically shifted right by 6, then clamped to 0..255.
- R6: Each line yields exactly `cfg_out_width` outputs (at least 1). The first carries `out_sol` and the last carries `out_eol`, and no further output appears until a new line closes.
- R7: `in_ready` is high only while a line is being collected. A sample with `in_sol` is stored at index 0. The line closes on the sample that brings the count to `cfg_in_width` or that carries `in_eol`, whichever comes first, and the stored count becomes the line length.
- R8: While `out_valid` is high and `out_ready` is low, `out_data`, `out_sol` and `out_eol` hold their values.
- R9: After reset `out_valid` is low, `in_ready` is high and both coefficient banks are zero, so a line filtered before any commit yields all-zero pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coef_we | input | 1 | Staging bank write enable |
| coef_addr | input | CA_W | Staging word address (phase*2+half) |
| coef_wdata | input | 32 | Four packed signed taps |
| coef_commit | input | 1 | Copy staging bank to working bank |
| cfg_in_width | input | LEN_W | Samples per input line |
| cfg_out_width | input | OUTW_W | Pixels per output line |
| cfg_step | input | 32 | 16.16 position increment per output |
| cfg_init_phase | input | 32 | 16.16 starting position per line |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block accepts a sample |
| in_data | input | 8 | Input sample |
| in_sol | input | 1 | First sample of a line |
| in_eol | input | 1 | Last sample of a line |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Consumer accepts the pixel |
| out_data | output | 8 | Filtered pixel |
| out_sol | output | 1 | First pixel of the output line |
| out_eol | output | 1 | Last pixel of the output line |

## Verification
The bench builds the block with a 24-sample line store and the default 12-bit output width counter. This keeps every input width from 1 to 24 and every output width from 1 to 24 within a short sweep. That sweep covers both edge-replication limits, single-sample and single-pixel lines, and ratios on both sides of unity. Two computed coefficient tables exercise the phase selection. One table has enough negative weight to drive results past both clamp limits, and the other reduces to a pure pass-through at phase 0.

// File: rtl/hscale_pkg.sv
package hscale_pkg;

    localparam int PIX_W          = 8;
    localparam int COEF_W         = 8;
    localparam int TAPS           = 8;
    localparam int PHASES         = 32;
    localparam int WORD_W         = 32;
    localparam int CENTRE_TAP     = 3;
    localparam int POS_W          = 32;
    localparam int FRAC_W         = 16;
    localparam int UNITY_SHIFT    = 6;

    localparam int TAPS_PER_WORD  = WORD_W / COEF_W;
    localparam int WORDS_PER_PHASE = TAPS / TAPS_PER_WORD;
    localparam int PH_W           = $clog2(PHASES);
    localparam int INT_W          = POS_W - FRAC_W;
    localparam int SUM_W          = PIX_W + COEF_W + $clog2(TAPS) + 1;

    localparam logic signed [SUM_W-1:0] ROUND_BIAS = SUM_W'(1) <<< (UNITY_SHIFT - 1);
    localparam logic signed [SUM_W-1:0] PIX_MAX    = SUM_W'((1 << PIX_W) - 1);

    typedef logic signed [COEF_W-1:0] coef_t;
    typedef coef_t [TAPS-1:0]         coef_vec_t;
    typedef logic [TAPS-1:0][PIX_W-1:0] pix_vec_t;

    typedef enum logic {ST_FILL, ST_EMIT} hs_state_e;

    typedef struct packed {
        logic [PIX_W-1:0] data;
        logic             sol;
        logic             eol;
    } out_beat_t;

    function automatic logic [PIX_W-1:0] round_sat(input logic signed [SUM_W-1:0] s);
        logic signed [SUM_W-1:0] r;
        r = (s + ROUND_BIAS) >>> UNITY_SHIFT;
        if (r < 0)
            return '0;
        else if (r > PIX_MAX)
            return '1;
        else
            return PIX_W'(r);
    endfunction

endpackage

// File: rtl/hscale_coef_bank.sv
module hscale_coef_bank
    import hscale_pkg::*;
#(
    parameter int NWORDS = PHASES * WORDS_PER_PHASE,
    parameter int AW     = $clog2(NWORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              commit,
    input  logic [PH_W-1:0]   phase,
    output coef_vec_t         taps
);

    logic [NWORDS-1:0][WORD_W-1:0] stage_q;
    logic [NWORDS-1:0][WORD_W-1:0] active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q  <= '0;
            active_q <= '0;
        end else begin
            if (commit)
                active_q <= stage_q;
            if (we)
                stage_q[waddr] <= wdata;
        end
    end

    for (genvar w = 0; w < WORDS_PER_PHASE; w++) begin : g_half
        logic [AW-1:0] word_idx;
        assign word_idx = AW'(int'(phase) * WORDS_PER_PHASE + w);
        for (genvar b = 0; b < TAPS_PER_WORD; b++) begin : g_lane
            assign taps[w*TAPS_PER_WORD + b] = coef_t'(active_q[word_idx][b*COEF_W +: COEF_W]);
        end
    end

endmodule

// File: rtl/hscale_line_store.sv
module hscale_line_store
    import hscale_pkg::*;
#(
    parameter int MAX_W = 64,
    parameter int LEN_W = $clog2(MAX_W + 1),
    parameter int IDX_W = $clog2(MAX_W)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [PIX_W-1:0] wdata,
    input  logic [INT_W-1:0] centre,
    input  logic [LEN_W-1:0] len,
    output pix_vec_t         taps
);

    logic [PIX_W-1:0] mem [MAX_W];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    logic signed [INT_W+1:0] len_s;
    logic [IDX_W-1:0]        last_idx;
    assign len_s    = (INT_W + 2)'(len);
    assign last_idx = IDX_W'(len - 1'b1);

    for (genvar t = 0; t < TAPS; t++) begin : g_tap
        localparam int OFS = t - CENTRE_TAP;
        logic signed [INT_W+1:0] pos;
        logic [IDX_W-1:0]        sel;
        always_comb begin
            pos = $signed({2'b00, centre}) + (INT_W + 2)'(OFS);
            if (pos < 0)
                sel = '0;
            else if (pos >= len_s)
                sel = last_idx;
            else
                sel = IDX_W'(pos);
        end
        assign taps[t] = mem[sel];
    end

endmodule

// File: rtl/hscale_fir.sv
module hscale_fir
    import hscale_pkg::*;
(
    input  pix_vec_t         pix,
    input  coef_vec_t        coef,
    output logic [PIX_W-1:0] y
);

    logic signed [SUM_W-1:0] sum;

    always_comb begin
        sum = '0;
        for (int t = 0; t < TAPS; t++) begin
            sum = sum + SUM_W'($signed({1'b0, pix[t]})) * SUM_W'(coef[t]);
        end
    end

    assign y = round_sat(sum);

endmodule

// File: rtl/hscale_top.sv
module hscale_top
    import hscale_pkg::*;
#(
    parameter int MAX_W  = 64,
    parameter int OUTW_W = 12,
    parameter int LEN_W  = $clog2(MAX_W + 1),
    parameter int CA_W   = $clog2(PHASES * WORDS_PER_PHASE)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              coef_we,
    input  logic [CA_W-1:0]   coef_addr,
    input  logic [WORD_W-1:0] coef_wdata,
    input  logic              coef_commit,
    input  logic [LEN_W-1:0]  cfg_in_width,
    input  logic [OUTW_W-1:0] cfg_out_width,
    input  logic [POS_W-1:0]  cfg_step,
    input  logic [POS_W-1:0]  cfg_init_phase,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [PIX_W-1:0]  in_data,
    input  logic              in_sol,
    input  logic              in_eol,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [PIX_W-1:0]  out_data,
    output logic              out_sol,
    output logic              out_eol
);

    localparam int IDX_W = $clog2(MAX_W);

    hs_state_e         state_q;
    logic [LEN_W-1:0]  wr_cnt_q, line_len_q, wr_addr, next_cnt;
    logic [OUTW_W-1:0] out_w_q, k_q;
    logic [POS_W-1:0]  step_q, acc_q;
    out_beat_t         beat_q;
    logic              out_valid_q;

    coef_vec_t         taps_c;
    pix_vec_t          pix_c;
    logic [PIX_W-1:0]  y_c;
    logic              accept, close_line, emit_load, last_out;

    assign in_ready   = (state_q == ST_FILL);
    assign accept     = in_valid && in_ready;
    assign wr_addr    = in_sol ? '0 : wr_cnt_q;
    assign next_cnt   = wr_addr + 1'b1;
    assign close_line = (next_cnt == cfg_in_width) || in_eol || (next_cnt == LEN_W'(MAX_W));
    assign emit_load  = (state_q == ST_EMIT) && (!out_valid_q || out_ready);
    assign last_out   = (k_q == out_w_q - 1'b1);

    hscale_coef_bank u_coef (
        .clk    (clk),
        .rst    (rst),
        .we     (coef_we),
        .waddr  (coef_addr),
        .wdata  (coef_wdata),
        .commit (coef_commit),
        .phase  (acc_q[FRAC_W-1 -: PH_W]),
        .taps   (taps_c)
    );

    hscale_line_store #(
        .MAX_W (MAX_W),
        .LEN_W (LEN_W),
        .IDX_W (IDX_W)
    ) u_line (
        .clk    (clk),
        .we     (accept),
        .waddr  (wr_addr[IDX_W-1:0]),
        .wdata  (in_data),
        .centre (acc_q[POS_W-1:FRAC_W]),
        .len    (line_len_q),
        .taps   (pix_c)
    );

    hscale_fir u_fir (
        .pix  (pix_c),
        .coef (taps_c),
        .y    (y_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_FILL;
            wr_cnt_q    <= '0;
            line_len_q  <= '0;
            out_w_q     <= '0;
            k_q         <= '0;
            step_q      <= '0;
            acc_q       <= '0;
            beat_q      <= '0;
            out_valid_q <= 1'b0;
        end else begin
            if (emit_load) begin
                beat_q      <= '{data: y_c, sol: (k_q == '0), eol: last_out};
                out_valid_q <= 1'b1;
                acc_q       <= acc_q + step_q;
                k_q         <= k_q + 1'b1;
                if (last_out)
                    state_q <= ST_FILL;
            end else if (out_ready) begin
                out_valid_q <= 1'b0;
            end

            if (accept) begin
                if (close_line) begin
                    state_q    <= ST_EMIT;
                    line_len_q <= next_cnt;
                    wr_cnt_q   <= '0;
                    out_w_q    <= cfg_out_width;
                    step_q     <= cfg_step;
                    acc_q      <= cfg_init_phase;
                    k_q        <= '0;
                end else begin
                    wr_cnt_q   <= next_cnt;
                end
            end
        end
    end

    assign out_valid = out_valid_q;
    assign out_data  = beat_q.data;
    assign out_sol   = beat_q.sol;
    assign out_eol   = beat_q.eol;

endmodule

// File: rtl/hscale_checker.sv
module hscale_checker #(
    parameter int NWORDS = 64,
    parameter int WORD_W = 32,
    parameter int PIX_W  = 8,
    parameter int CNT_W  = 16
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          in_valid,
    input logic                          in_ready,
    input logic                          in_eol,
    input logic                          out_valid,
    input logic                          out_ready,
    input logic [PIX_W-1:0]              out_data,
    input logic                          out_sol,
    input logic                          out_eol,
    input logic                          coef_commit,
    input logic [NWORDS-1:0][WORD_W-1:0] active_bank
);

    logic [CNT_W-1:0] n_out_q;

    always_ff @(posedge clk) begin
        if (rst)
            n_out_q <= '0;
        else if (out_valid && out_ready)
            n_out_q <= out_eol ? '0 : n_out_q + 1'b1;
    end

    // R8: stalled output beat is held
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sol) && $stable(out_eol));

    // R2: working bank only moves on a commit
    p_coef_frozen_r2: assert property (@(posedge clk) disable iff (rst)
        !coef_commit |=> $stable(active_bank));

    // R6: start flag exactly on the first beat of each line
    p_sol_first_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready |-> (out_sol == (n_out_q == '0)));

    // R7: no collection while a line is still being emitted
    p_idle_while_emit_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_eol |-> !in_ready);

    // R7: accepted end-of-line closes the line
    p_close_r7: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && in_eol |=> !in_ready);

endmodule

bind hscale_top hscale_checker #(
    .NWORDS (hscale_pkg::PHASES * hscale_pkg::WORDS_PER_PHASE),
    .WORD_W (hscale_pkg::WORD_W),
    .PIX_W  (hscale_pkg::PIX_W),
    .CNT_W  (16)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_eol      (in_eol),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_data    (out_data),
    .out_sol     (out_sol),
    .out_eol     (out_eol),
    .coef_commit (coef_commit),
    .active_bank (u_coef.active_q)
);

// File: tb/hscale_top_tb_top.sv
module hscale_top_tb_top;

    localparam int MAX_W  = 24;
    localparam int OUTW_W = 12;
    localparam int LEN_W  = $clog2(MAX_W + 1);
    localparam int CA_W   = 6;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              coef_we = 1'b0;
    logic [CA_W-1:0]   coef_addr = '0;
    logic [31:0]       coef_wdata = '0;
    logic              coef_commit = 1'b0;
    logic [LEN_W-1:0]  cfg_in_width = '0;
    logic [OUTW_W-1:0] cfg_out_width = '0;
    logic [31:0]       cfg_step = '0;
    logic [31:0]       cfg_init_phase = '0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [7:0]        in_data = '0;
    logic              in_sol = 1'b0;
    logic              in_eol = 1'b0;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [7:0]        out_data;
    logic              out_sol;
    logic              out_eol;

    always #10 clk = ~clk;

    hscale_top #(.MAX_W(MAX_W), .OUTW_W(OUTW_W)) dut_i (
        .clk(clk), .rst(rst), .coef_we(coef_we), .coef_addr(coef_addr),
        .coef_wdata(coef_wdata), .coef_commit(coef_commit),
        .cfg_in_width(cfg_in_width), .cfg_out_width(cfg_out_width),
        .cfg_step(cfg_step), .cfg_init_phase(cfg_init_phase),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sol(in_sol), .in_eol(in_eol), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_sol(out_sol),
        .out_eol(out_eol)
    );

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    int coef_tbl [3][32][8];
    int line_px  [64];
    int rd_data  [64];
    int rd_sol   [64];
    int rd_eol   [64];

    task automatic check(input string tag, input int k, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s idx=%0d actual=%0d expected=%0d", tag, k, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    function automatic int model(int k, int n, int init, int step, int tbl);
        logic [31:0] pos;
        int c, ph, sum, idx, r;
        pos = 32'(init) + 32'(k) * 32'(step);
        c   = int'(pos[31:16]);
        ph  = int'(pos[15:11]);
        sum = 0;
        for (int t = 0; t < 8; t++) begin
            idx = c + t - 3;
            if (idx < 0) idx = 0;
            if (idx > n - 1) idx = n - 1;
            sum += coef_tbl[tbl][ph][t] * line_px[idx];
        end
        r = (sum + 32) >>> 6;
        if (r < 0) r = 0;
        if (r > 255) r = 255;
        return r;
    endfunction

    task automatic fill_pattern(input int kind, input int n);
        for (int i = 0; i < n; i++) begin
            case (kind)
                0: line_px[i] = (i * 11) % 256;
                1: line_px[i] = (i * 73 + 19 + (i * i * 7)) % 256;
                default: line_px[i] = ((i % 4) == 1 || (i % 4) == 2) ? 255 : 0;
            endcase
        end
    endtask

    task automatic load_table(input int tbl);
        for (int p = 0; p < 32; p++) begin
            for (int w = 0; w < 2; w++) begin
                logic [31:0] word;
                word = '0;
                for (int b = 0; b < 4; b++)
                    word = word | (32'(coef_tbl[tbl][p][w*4+b] & 255) << (8 * b));
                @(negedge clk);
                coef_we    = 1'b1;
                coef_addr  = CA_W'(p * 2 + w);
                coef_wdata = word;
            end
        end
        @(negedge clk);
        coef_we = 1'b0;
    endtask

    task automatic commit();
        @(negedge clk);
        coef_commit = 1'b1;
        @(negedge clk);
        coef_commit = 1'b0;
    endtask

    task automatic run_line(input string tag, input int n_send, input int cfg_in, input int nout,
                            input int init, input int tbl, input bit backp, input bit restart);
        int step;
        int total;
        step  = (n_send << 16) / nout;
        total = restart ? n_send + 2 : n_send;
        @(negedge clk);
        cfg_in_width   = LEN_W'(cfg_in);
        cfg_out_width  = OUTW_W'(nout);
        cfg_step       = 32'(step);
        cfg_init_phase = 32'(init);
        fork
            begin : drive_in
                for (int i = 0; i < total; i++) begin
                    @(negedge clk);
                    in_valid = 1'b1;
                    if (restart && i < 2) begin
                        in_data = 8'(165 + i);
                        in_sol  = (i == 0);
                        in_eol  = 1'b0;
                    end else begin
                        int j;
                        j = restart ? i - 2 : i;
                        in_data = 8'(line_px[j]);
                        in_sol  = (j == 0);
                        in_eol  = (j == n_send - 1);
                    end
                    while (!in_ready) @(negedge clk);
                end
                @(negedge clk);
                in_valid = 1'b0;
                in_sol   = 1'b0;
                in_eol   = 1'b0;
            end
            begin : grab_out
                int got;
                int cyc;
                got = 0;
                cyc = 0;
                while (got < nout) begin
                    @(negedge clk);
                    cyc++;
                    out_ready = backp ? ((cyc % 3) != 0) : 1'b1;
                    if (out_valid && out_ready) begin
                        rd_data[got] = int'(out_data);
                        rd_sol[got]  = int'(out_sol);
                        rd_eol[got]  = int'(out_eol);
                        got++;
                    end
                end
            end
        join
        @(negedge clk);
        out_ready = 1'b1;
        @(negedge clk);
        for (int k = 0; k < nout; k++) begin
            check(tag, k, rd_data[k], model(k, n_send, init, step, tbl));
            check("R6 sol", k, rd_sol[k], (k == 0) ? 1 : 0);
            check("R6 eol", k, rd_eol[k], (k == nout - 1) ? 1 : 0);
        end
        check("R6 no extra output", nout, int'(out_valid), 0);
        check("R7 ready for next line", nout, int'(in_ready), 1);
    endtask

    initial begin
        for (int p = 0; p < 32; p++) begin
            int q, r;
            q = p % 4;
            r = p % 3;
            for (int t = 0; t < 8; t++) begin
                coef_tbl[0][p][t] = 0;
                coef_tbl[1][p][t] = 0;
                coef_tbl[2][p][t] = 0;
            end
            coef_tbl[0][p][2] = -q;
            coef_tbl[0][p][3] = 64 - 2 * p + q;
            coef_tbl[0][p][4] = 2 * p + q;
            coef_tbl[0][p][5] = -q;
            coef_tbl[1][p][0] = -r;
            coef_tbl[1][p][1] = -8;
            coef_tbl[1][p][3] = 40 + r;
            coef_tbl[1][p][4] = 40 + r;
            coef_tbl[1][p][6] = -8;
            coef_tbl[1][p][7] = -r;
        end

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R9 reset out_valid", 0, int'(out_valid), 0);
        check("R9 reset in_ready", 0, int'(in_ready), 1);

        // R9: banks are zero before any commit
        fill_pattern(1, 12);
        run_line("R9 zero bank", 12, 12, 9, 0, 2, 1'b0, 1'b0);

        load_table(0);
        commit();

        fill_pattern(0, 16);
        run_line("R3 identity", 16, 16, 16, 0, 0, 1'b0, 1'b0);
        fill_pattern(1, 24);
        run_line("R3 downscale", 24, 24, 10, 32'h400, 0, 1'b0, 1'b0);
        fill_pattern(1, 10);
        run_line("R4 upscale edges", 10, 10, 24, 32'h8000, 0, 1'b0, 1'b0);
        fill_pattern(0, 16);
        run_line("R3 init phase", 16, 16, 16, 32'hFC000, 0, 1'b0, 1'b0);

        // R2: staged table B stays inactive until committed
        load_table(1);
        fill_pattern(1, 12);
        run_line("R2 staged only", 12, 12, 12, 0, 0, 1'b0, 1'b0);
        commit();

        fill_pattern(2, 16);
        run_line("R5 R1 saturate", 16, 16, 16, 0, 1, 1'b0, 1'b0);
        fill_pattern(1, 20);
        run_line("R8 backpressure", 20, 20, 13, 32'h400, 1, 1'b1, 1'b0);
        fill_pattern(1, 9);
        run_line("R7 early eol", 9, 20, 15, 0, 1, 1'b0, 1'b0);
        fill_pattern(0, 12);
        run_line("R7 sol restart", 12, 12, 7, 0, 1, 1'b0, 1'b1);

        for (int ow = 1; ow <= 24; ow++) begin
            fill_pattern(1, 24);
            run_line("R6 out width sweep", 24, 24, ow, 0, 1, (ow % 2) == 1, 1'b0);
        end
        for (int iw = 1; iw <= 24; iw++) begin
            fill_pattern(2, iw);
            run_line("R4 in width sweep", iw, iw, 8, 32'h400, 1, 1'b0, 1'b0);
        end

        finish_run();
    end

endmodule